// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a serial peripheral interface master that a processor drives through a small word-addressed register bus. Software selects a word length of 8, 16 or 32 bits, an idle clock level, the clock edge on which data moves and the point in each bit at which the input line is sampled. It also programs a clock divider and then writes words into a transmit queue. The block shifts each queued word out MSB first on `mosi`. At the same time it collects the bits arriving on `miso` into a receive queue, and software drains that queue by reading the data address.

Each queue has a fixed budget of 16 bytes, so it holds 16, 8 or 4 words depending on the word length. Turning the deep-queue option off leaves a single word per queue. Every register can be written in three ways: a plain write, an atomic clear of the masked bits, or an atomic set of the masked bits. An optional hardware chip-select holds `ss_n` low for as long as words are queued or one is being shifted. A received word that finds the receive queue full is dropped, and a sticky overflow flag records the loss until software clears it.

Top module: `spi_fifo_master`

## Requirements
- R1: `bus_addr[3:2]` selects the register: 0 control, 1 status, 2 data, 3 divider. `bus_addr[1:0]` selects the access: 0 plain write, 1 clear-mask, 2 set-mask, 3 write ignored. Reads return the register whatever the access code. After reset every register reads zero, `ss_n` is 1, and `sck` and `mosi` are 0.
- R2: Control bits that can be written: 5 master, 6 idle clock level, 8 edge select, 9 sample point, 11:10 word length, 15 enable, 16 deep queues, 28 hardware chip-select. Every other bit, bit 31 among them, reads 0. The clear and set accesses change only the bits given in the mask. These rules apply to the control and divider registers.
- R3: The divider register holds 9 bits. Each half of a bit time lasts divider+1 clocks, so the first and last `sck` transitions of a W-bit word lie (2W-1)·(divider+1) clocks apart.
- R4: Word length code 00 gives 8 bits, 01 gives 16 bits, and 10 or 11 gives 32 bits. Bits leave MSB first. Each bit is held on `mosi` across the `sck` transition at the middle of its bit time.
- R5: When no transfer is running, `sck` equals control bit 6. Each word produces exactly 2W `sck` transitions. With bit 8 set, the first transition comes at mid-bit. With bit 8 clear, it comes at the start of the bit.
- R6: With control bit 9 clear, `miso` is sampled at the end of the first half of each bit. With bit 9 set, it is sampled at the end of the second half. The received word is zero-extended into the low W bits.
- R7: Status bits 20:16 hold the transmit queue level and bits 28:24 hold the receive queue level, both counted in words. With bit 16 set, a queue holds 16, 8 or 4 words for 8, 16 or 32-bit words. With bit 16 clear, it holds 1 word. A push beyond that capacity is dropped.
- R8: A plain write to the data address pushes into the transmit queue, but only while enabled. A read of the data address returns the oldest received word and removes it. When the receive queue is empty, the read returns 0.
- R9: A word starts shifting only when the enable bit and the master bit are both set and the transmit queue is not empty.
- R10: A word that completes while the receive queue is full is discarded and sets status bit 6. Only a clear-mask write to the status register with bit 6 set clears that flag. All other status writes leave it unchanged.
- R11: With control bit 28 set and the block enabled, `ss_n` is 0 while a word is shifting or the transmit queue is not empty, and 1 otherwise. Across back-to-back words it stays 0. With bit 28 clear, `ss_n` stays 1.
- R12: Clearing the enable bit aborts the running word, returns `sck` to idle and `mosi` to 0, and empties both queues. All other control bits and the divider keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register select (3:2) and access code (1:0) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the data address pops the receive queue |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Chip-select, active low |

## Verification
Several properties are checked on every clock. The overflow flag survives every write except its own clear. Each queue level stays within its storage. The serial clock changes only when a half-bit count expires. A started word always consumes a transmit entry. A disabled block empties its queues in the next cycle. The idle clock level and the released chip-select are checked whenever no word is in flight. Word contents, MSB-first ordering, the sample point, per-mode transition counts and word duration can only be shown by the bench. It sweeps every word length, all eight clock and sample combinations and three divider values. `miso` is looped back from `mosi` through a one-clock delay, so a mid-bit sample at the fastest divider sees the preceding bit and the expected word is the transmitted word shifted right by one.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DW = 32;

    // control register bit positions
    localparam int C_MASTER = 5;
    localparam int C_CPOL   = 6;
    localparam int C_EDGE   = 8;
    localparam int C_LATE   = 9;
    localparam int C_WLEN   = 10;
    localparam int C_ENABLE = 15;
    localparam int C_DEEP   = 16;
    localparam int C_AUTOSS = 28;

    localparam logic [DW-1:0] CTRL_WMASK = 32'h1001_8F60;

    // status register fields
    localparam int S_OVF    = 6;
    localparam int S_TXLVL  = 16;
    localparam int S_RXLVL  = 24;
    localparam int S_LVL_W  = 5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_DIV  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_RAW  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_SET  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    function automatic logic [5:0] word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd8;
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [DW-1:0] low_mask(input logic [5:0] nbits);
        logic [63:0] m;
        m = (64'd1 << nbits) - 64'd1;
        return m[DW-1:0];
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic [LW-1:0] cap,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.lvl >= cap);
    assign empty   = (q.lvl == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[q.rp];
    assign level   = q.lvl;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = step(q.wp);
            if (do_pop)  d.rp = step(q.rp);
            d.lvl = q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lvl <= LW'(DEPTH));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start_ok,
    input  logic [DW-1:0]    tx_word,
    input  logic [1:0]       wlen,
    input  logic             cpol,
    input  logic             edge_sel,
    input  logic             late,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [DW-1:0]    rx_word,
    output logic             busy,
    output logic             sck,
    output logic             mosi
);

    typedef struct packed {
        logic             busy;
        logic             half;
        logic [DIV_W-1:0] tick;
        logic [5:0]       bitn;
        logic [5:0]       nbits;
        logic [DW-1:0]    tsh;
        logic [DW-1:0]    rsh;
    } sh_st_t;

    sh_st_t q, d;
    logic [5:0]    bits_now;
    logic [DW-1:0] rx_next;

    assign bits_now = word_bits(wlen);
    assign rx_next  = {q.rsh[DW-2:0], miso};

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = '0;
        if (clear) begin
            d.busy = 1'b0;
            d.half = 1'b0;
            d.tick = '0;
            d.bitn = '0;
        end else if (!q.busy) begin
            if (start_ok) begin
                tx_pop  = 1'b1;
                d.busy  = 1'b1;
                d.half  = 1'b0;
                d.tick  = '0;
                d.bitn  = '0;
                d.nbits = bits_now;
                d.tsh   = tx_word << (6'(DW) - bits_now);
                d.rsh   = '0;
            end
        end else if (q.tick != div) begin
            d.tick = q.tick + 1'b1;
        end else begin
            d.tick = '0;
            if (!q.half) begin
                d.half = 1'b1;
                if (!late) d.rsh = rx_next;
            end else begin
                d.half = 1'b0;
                if (late) d.rsh = rx_next;
                d.tsh  = q.tsh << 1;
                d.bitn = q.bitn + 1'b1;
                if (q.bitn == q.nbits - 6'd1) begin
                    d.busy  = 1'b0;
                    rx_push = 1'b1;
                    rx_word = (late ? rx_next : q.rsh) & low_mask(q.nbits);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign sck  = q.busy ? (cpol ^ (edge_sel ? q.half : ~q.half)) : cpol;
    assign mosi = q.busy & q.tsh[DW-1];

    // R9
    start_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(tx_pop));

    // R3
    sck_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sck) && $past(q.busy) && q.busy && $stable(cpol) && $stable(edge_sel))
        |-> $past(q.tick == div));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    parameter int DIV_W      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          ss_n
);

    localparam int LW    = $clog2(FIFO_BYTES + 1);
    localparam int CAP8  = FIFO_BYTES;
    localparam int CAP16 = (FIFO_BYTES + 1) / 2;
    localparam int CAP32 = (FIFO_BYTES + 3) / 4;

    typedef struct packed {
        logic [DW-1:0]    ctrl;
        logic [DIV_W-1:0] baud;
        logic             ovf;
    } regs_t;

    regs_t r_q, r_d;

    reg_sel_e sel;
    acc_e     acc;
    logic     on, master, cpol, edge_sel, late, deep, autoss;
    logic [1:0]    wlen;
    logic [LW-1:0] cap;

    logic          tx_push, tx_pop, tx_full, tx_empty;
    logic [DW-1:0] tx_head;
    logic [LW-1:0] tx_level;
    logic          rx_push, rx_pop, rx_full, rx_empty;
    logic [DW-1:0] rx_word, rx_head;
    logic [LW-1:0] rx_level;
    logic          sh_busy;

    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign acc      = acc_e'(bus_addr[1:0]);
    assign on       = r_q.ctrl[C_ENABLE];
    assign master   = r_q.ctrl[C_MASTER];
    assign cpol     = r_q.ctrl[C_CPOL];
    assign edge_sel = r_q.ctrl[C_EDGE];
    assign late     = r_q.ctrl[C_LATE];
    assign deep     = r_q.ctrl[C_DEEP];
    assign autoss   = r_q.ctrl[C_AUTOSS];
    assign wlen     = r_q.ctrl[C_WLEN +: 2];

    always_comb begin
        if (!deep) begin
            cap = LW'(1);
        end else begin
            case (wlen)
                2'b00:   cap = LW'(CAP8);
                2'b01:   cap = LW'(CAP16);
                default: cap = LW'(CAP32);
            endcase
        end
    end

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] wd,
                                            input acc_e          a,
                                            input logic [DW-1:0] keep);
        case (a)
            ACC_RAW: return wd & keep;
            ACC_CLR: return old & ~wd;
            ACC_SET: return (old | wd) & keep;
            default: return old;
        endcase
    endfunction

    // register next state
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (sel)
                REG_CTRL: r_d.ctrl = merge(r_q.ctrl, bus_wdata, acc, CTRL_WMASK);
                REG_DIV:  r_d.baud = DIV_W'(merge(DW'(r_q.baud), bus_wdata, acc,
                                                  DW'({DIV_W{1'b1}})));
                REG_STAT: if (acc == ACC_CLR && bus_wdata[S_OVF]) r_d.ovf = 1'b0;
                default:  ;
            endcase
        end
        if (rx_push && rx_full) r_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_push = bus_wr && (sel == REG_DATA) && (acc == ACC_RAW) && on;
    assign rx_pop  = bus_rd && (sel == REG_DATA);

    // read path
    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_CTRL: bus_rdata = r_q.ctrl;
            REG_STAT: begin
                bus_rdata[S_OVF]                 = r_q.ovf;
                bus_rdata[S_TXLVL +: S_LVL_W]    = S_LVL_W'(tx_level);
                bus_rdata[S_RXLVL +: S_LVL_W]    = S_LVL_W'(rx_level);
            end
            REG_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = DW'(r_q.baud);
        endcase
    end

    spim_fifo #(.DEPTH(FIFO_BYTES), .DW(DW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!on),
        .push  (tx_push),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .cap   (cap),
        .rdata (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_fifo #(.DEPTH(FIFO_BYTES), .DW(DW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!on),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .cap   (cap),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spim_shifter #(.DIV_W(DIV_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!on),
        .start_ok (on && master && !tx_empty),
        .tx_word  (tx_head),
        .wlen     (wlen),
        .cpol     (cpol),
        .edge_sel (edge_sel),
        .late     (late),
        .div      (r_q.baud),
        .miso     (miso),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .busy     (sh_busy),
        .sck      (sck),
        .mosi     (mosi)
    );

    assign ss_n = !(autoss && on && (sh_busy || !tx_empty));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.ovf) && !($past(bus_wr) && $past(sel) == REG_STAT &&
          $past(acc) == ACC_CLR && $past(bus_wdata[S_OVF]))) |-> r_q.ovf);

    // R12
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (tx_level == '0 && rx_level == '0));

    // R5
    idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> (sck == cpol));

    // R11
    ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_busy && tx_empty) |-> ss_n);

    // silence tx_full: the queue gates pushes itself
    logic unused_ok;
    assign unused_ok = tx_full;

endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] B_MST  = 32'h0000_0020;
    localparam logic [31:0] B_CPOL = 32'h0000_0040;
    localparam logic [31:0] B_EDGE = 32'h0000_0100;
    localparam logic [31:0] B_LATE = 32'h0000_0200;
    localparam logic [31:0] B_ON   = 32'h0000_8000;
    localparam logic [31:0] B_DEEP = 32'h0001_0000;
    localparam logic [31:0] B_SS   = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, ss_n;
    logic        miso_d = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // monitor state
    logic        mon_en = 1'b0;
    logic        mon_cpol = 1'b0;
    logic        mon_edge = 1'b0;
    int          edges = 0;
    time         t_first = 0;
    time         t_last = 0;
    logic [31:0] capw = '0;
    logic        ss_mon = 1'b0;
    int          ss_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso_d),
        .ss_n      (ss_n)
    );

    // one-clock delayed loopback
    always @(posedge clk) miso_d <= mosi;

    always @(sck) begin
        if (mon_en) begin
            edges = edges + 1;
            if (edges == 1) t_first = $time;
            t_last = $time;
            if (mon_edge ? (sck != mon_cpol) : (sck == mon_cpol))
                capw = {capw[30:0], mosi};
        end
    end

    always @(posedge ss_n) if (ss_mon) ss_rises = ss_rises + 1;

    function automatic logic [3:0] ad(input int r, input int a);
        return {r[1:0], a[1:0]};
    endfunction

    function automatic logic [31:0] fmask(input int bits);
        return (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    endfunction

    function automatic logic [31:0] pat(input int i);
        return (32'h9E37_79B9 * i) + 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] dt);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = dt;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] dt);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        dt = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(ad(1, 0), s);
            if (int'(s[28:24]) >= n) break;
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, tx, exp, cw;
        int bits, divv, idx;
        logic cp, ce, lt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(ad(0, 0), v); chk("R1 ctrl reset", v, 32'h0);
        rd(ad(1, 0), v); chk("R1 stat reset", v, 32'h0);
        rd(ad(2, 0), v); chk("R1 data reset", v, 32'h0);
        rd(ad(3, 0), v); chk("R1 div reset", v, 32'h0);
        chk("R1 pins reset", {29'd0, ss_n, sck, mosi}, 32'h4);

        // R2 write mask and aliases on control
        wr(ad(0, 0), 32'hFFFF_FFFF);
        rd(ad(0, 0), v); chk("R2 ctrl raw mask", v, 32'h1001_8F60);
        wr(ad(0, 1), 32'h0000_8020);
        rd(ad(0, 0), v); chk("R2 ctrl clr alias", v, 32'h1001_0F40);
        wr(ad(0, 2), 32'h8000_0020);
        rd(ad(0, 0), v); chk("R2 ctrl set alias", v, 32'h1001_0F60);
        wr(ad(0, 0), 32'h0);
        wr(ad(0, 3), 32'hFFFF_FFFF);
        rd(ad(0, 2), v); chk("R1 access 3 ignored", v, 32'h0);

        // R3 divider width and aliases
        wr(ad(3, 0), 32'h0000_FFFF);
        rd(ad(3, 0), v); chk("R3 div raw", v, 32'h1FF);
        wr(ad(3, 1), 32'h0000_00F0);
        rd(ad(3, 0), v); chk("R3 div clr", v, 32'h10F);
        wr(ad(3, 2), 32'h0000_0020);
        rd(ad(3, 0), v); chk("R3 div set", v, 32'h12F);

        // R7 capacity per word length / R12 flush / R8 push gated by enable
        for (int w = 0; w < 3; w++) begin
            for (int dp = 0; dp < 2; dp++) begin
                cw = (dp != 0 ? B_DEEP : 32'h0) | (32'(w) << 10);
                wr(ad(0, 0), B_ON | cw);
                for (int k = 0; k < 20; k++) wr(ad(2, 0), pat(k));
                rd(ad(1, 0), v);
                exp = (dp == 0) ? 32'd1 : 32'(16 >> w);
                chk("R7 tx capacity", {27'd0, v[20:16]}, exp);
                wr(ad(0, 1), B_ON);
                rd(ad(1, 0), v); chk("R12 flush on disable", v, 32'h0);
                rd(ad(0, 0), v); chk("R12 config kept", v, cw);
                wr(ad(2, 0), 32'h1234);
                rd(ad(1, 0), v); chk("R8 push while disabled", v, 32'h0);
            end
        end

        // R9 no shifting without master
        wr(ad(3, 0), 32'h0);
        wr(ad(0, 0), B_ON | B_DEEP);
        @(negedge clk);
        edges = 0; mon_cpol = 1'b0; mon_edge = 1'b0; mon_en = 1'b1;
        wr(ad(2, 0), 32'h3C);
        repeat (40) @(negedge clk);
        chk("R9 idle without master", 32'(edges), 32'h0);
        rd(ad(1, 0), v); chk("R9 word stays queued", {27'd0, v[20:16]}, 32'h1);
        mon_en = 1'b0;
        wr(ad(0, 2), B_MST);
        wait_rx(1);
        rd(ad(2, 0), v); chk("R9 starts with master", v, 32'h1E);

        // sweep: word length x clock mode x sample point x divider
        idx = 1;
        for (int w = 0; w < 3; w++) begin
            for (int m = 0; m < 8; m++) begin
                for (int dv = 0; dv < 3; dv++) begin
                    bits = 8 << w;
                    divv = (dv == 2) ? 3 : dv;
                    cp = m[0]; ce = m[1]; lt = m[2];
                    wr(ad(3, 0), 32'(divv));
                    wr(ad(0, 0), B_ON | B_MST | B_DEEP | B_SS | (32'(w) << 10) |
                                 (cp ? B_CPOL : 32'h0) | (ce ? B_EDGE : 32'h0) |
                                 (lt ? B_LATE : 32'h0));
                    @(negedge clk);
                    edges = 0; capw = '0; mon_cpol = cp; mon_edge = ce; mon_en = 1'b1;
                    tx = pat(idx) & fmask(bits);
                    idx++;
                    wr(ad(2, 0), tx);
                    chk("R11 ss asserted", {31'd0, ss_n}, 32'h0);
                    wait_rx(1);
                    rd(ad(2, 0), v);
                    exp = (!lt && divv == 0) ? (tx >> 1) : tx;
                    chk("R6 received word", v, exp);
                    chk("R4 mosi bits msb first", capw & fmask(bits), tx);
                    chk("R5 transition count", 32'(edges), 32'(2 * bits));
                    chk("R3 word duration", 32'((t_last - t_first) / CLK_PERIOD),
                        32'((2 * bits - 1) * (divv + 1)));
                    chk("R5 idle level", {31'd0, sck}, {31'd0, cp});
                    chk("R11 ss released", {31'd0, ss_n}, 32'h1);
                    mon_en = 1'b0;
                end
            end
        end

        // R11 chip-select off
        wr(ad(0, 0), B_ON | B_MST | B_DEEP);
        @(negedge clk);
        ss_rises = 0;
        wr(ad(2, 0), 32'hA5);
        chk("R11 ss idle when disabled", {31'd0, ss_n}, 32'h1);
        wait_rx(1);
        rd(ad(2, 0), v); chk("R8 pop data", v, 32'hA5);

        // R10 overflow and back-to-back chip-select
        wr(ad(3, 0), 32'h0);
        wr(ad(0, 0), B_ON | B_MST | B_DEEP | B_SS | B_LATE);
        @(negedge clk);
        ss_rises = 0; ss_mon = 1'b1;
        for (int k = 0; k < 16; k++) wr(ad(2, 0), pat(100 + k) & 32'hFF);
        wait_rx(16);
        chk("R11 ss held across words", 32'(ss_rises), 32'h1);
        ss_mon = 1'b0;
        rd(ad(1, 0), v); chk("R10 no overflow at capacity", v, 32'h1000_0000);
        wr(ad(2, 0), 32'h77);
        repeat (40) @(negedge clk);
        rd(ad(1, 0), v); chk("R10 overflow set", v, 32'h1000_0040);
        wr(ad(1, 0), 32'hFFFF_FFFF);
        rd(ad(1, 0), v); chk("R10 raw write keeps flag", v[6], 1'b1);
        wr(ad(1, 2), 32'hFFFF_FFFF);
        rd(ad(1, 0), v); chk("R10 set write keeps flag", v[6], 1'b1);
        wr(ad(1, 1), 32'hFFFF_FFBF);
        rd(ad(1, 0), v); chk("R10 clear without bit6 keeps flag", v[6], 1'b1);
        wr(ad(1, 1), 32'h0000_0040);
        rd(ad(1, 0), v); chk("R10 clear alias clears flag", v, 32'h1000_0000);
        for (int k = 0; k < 16; k++) begin
            rd(ad(2, 0), v);
            chk("R8 receive order", v, pat(100 + k) & 32'hFF);
        end
        rd(ad(2, 0), v); chk("R8 empty read", v, 32'h0);
        rd(ad(1, 0), v); chk("R10 dropped word absent", v, 32'h0);

        // R12 abort mid-word
        wr(ad(3, 0), 32'd3);
        cw = B_MST | B_DEEP | B_SS | B_CPOL | (32'd2 << 10);
        wr(ad(0, 0), B_ON | cw);
        wr(ad(2, 0), 32'hFFFF_FFFF);
        wr(ad(2, 0), 32'h8765_4321);
        repeat (20) @(negedge clk);
        chk("R11 ss during word", {31'd0, ss_n}, 32'h0);
        wr(ad(0, 1), B_ON);
        @(negedge clk);
        chk("R12 abort pins", {29'd0, ss_n, sck, mosi}, 32'h6);
        rd(ad(1, 0), v); chk("R12 queues empty", v, 32'h0);
        rd(ad(0, 0), v); chk("R12 config kept", v, cw);
        rd(ad(3, 0), v); chk("R12 divider kept", v, 32'd3);

        finish_run();
    end

endmodule